// File: doc/BRIEF.md
# Four-bit Arithmetic Logic Unit

This block is a purely combinational ALU with two operands, a three-bit function select and a carry input. It produces a result of the same width and a carry output. The width is a parameter and defaults to four bits.

When the top select bit is low, every result comes from a single ripple-carry adder. The adder always takes operand A on one side. The lower two select bits pick what goes on the other side: zero, B, the bitwise inverse of B, or all ones. The carry input is added into the sum. These four choices, each with the carry input at 0 or 1, give eight operations: transfer, increment, add, add plus one, subtract with borrow, subtract, decrement, and transfer again. When the top select bit is high, a per-bit logic stage drives the result instead, and a 2-to-1 selector on each bit picks between the two stages.

The ALU sits in a datapath between registers. Its outputs settle from its inputs alone and need no clock.

Top module: `nibble_alu`

## Requirements
- R1: With fsel[2]=0, res equals (opa + Y + cin) modulo 2^W. Y is the second adder input: fsel[1:0]=00 gives zero, 01 gives opb, 10 gives ~opb, and 11 gives all ones. So code 0000 is transfer A, 0001 is A+1, 0010 is A+B and 0011 is A+B+1, where the four digits are fsel[2:0] followed by cin.
- R2: With fsel[2]=0, cout is bit W of the full sum opa + Y + cin.
- R3: Code 0100 gives opa + ~opb, which is A−B−1. Code 0101 gives A−B in two's complement, with cout=1 exactly when opa >= opb (unsigned).
- R4: Code 0110 gives A−1, with cout=1 unless opa is zero. Code 0111 gives A unchanged, with cout=1.
- R5: With fsel[2]=1, cin has no effect. fsel[1:0]=00 gives opa|opb, 01 gives opa^opb, 10 gives opa&opb, and 11 gives ~opa.
- R6: With fsel[2]=1, cout is 0.
- R7: res and cout follow any change of the inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W | Operand A; always the first adder input |
| opb | input | W | Operand B |
| fsel | input | 3 | Function select; bit 2 picks the logic stage |
| cin | input | 1 | Carry into the least significant adder stage |
| res | output | W | Result |
| cout | output | 1 | Carry out of the most significant stage; 0 in logic mode |

## Verification
The assertions check, on every input change, properties that hold for any operand pair: the carry output is 0 in logic mode, every logic result is correct, the two transfer codes leave A unchanged, and subtraction and decrement give the right difference and carry. Some behaviour only the bench's exhaustive sweep can show. That includes the exact carry ripple of add and add-plus-one across all 256 operand pairs, the fact that cin has no effect in logic mode for every operand, and that outputs settle between clock edges when inputs change.

// File: rtl/nibble_alu.sv
module nibble_alu #(
  parameter int W = 4
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [2:0]   fsel,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);

  logic [W:0]   c;
  logic [W-1:0] arith;
  logic [W-1:0] logic_r;

  assign c[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic yb;

    always_comb begin
      unique case (fsel[1:0])
        2'b00:   yb = 1'b0;
        2'b01:   yb = opb[i];
        2'b10:   yb = ~opb[i];
        default: yb = 1'b1;
      endcase
    end

    assign arith[i] = opa[i] ^ yb ^ c[i];
    assign c[i+1]   = (opa[i] & yb) | (c[i] & (opa[i] ^ yb));

    always_comb begin
      unique case (fsel[1:0])
        2'b00:   logic_r[i] = opa[i] | opb[i];
        2'b01:   logic_r[i] = opa[i] ^ opb[i];
        2'b10:   logic_r[i] = opa[i] & opb[i];
        default: logic_r[i] = ~opa[i];
      endcase
    end

    assign res[i] = fsel[2] ? logic_r[i] : arith[i];
  end

  assign cout = ~fsel[2] & c[W];

endmodule

// File: rtl/nibble_alu_chk.sv
module nibble_alu_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [2:0]   fsel,
  input logic         cin,
  input logic [W-1:0] res,
  input logic         cout
);

  always_comb begin
    if (fsel[2])
      p_logic_nocarry_r6: assert (cout == 1'b0);
    if (fsel == 3'b100)
      p_or_r5: assert (res == (opa | opb));
    if (fsel == 3'b101)
      p_xor_r5: assert (res == (opa ^ opb));
    if (fsel == 3'b110)
      p_and_r5: assert (res == (opa & opb));
    if (fsel == 3'b111)
      p_not_r5: assert (res == ~opa);
    if (fsel == 3'b000 && !cin)
      p_transfer_r1: assert (res == opa && !cout);
    if (fsel == 3'b010 && cin)
      p_subtract_r3: assert (res == W'(opa - opb) && cout == (opa >= opb));
    if (fsel == 3'b011 && !cin)
      p_decrement_r4: assert (res == W'(opa - 1'b1) && cout == (opa != '0));
    if (fsel == 3'b011 && cin)
      p_wrap_r4: assert (res == opa && cout);
  end

endmodule

bind nibble_alu nibble_alu_chk #(.W(W)) u_chk (.*);

// File: tb/test_nibble_alu.sv
module test_nibble_alu;
  localparam int W = 4;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 10000;

  logic clk = 1'b0;
  logic [W-1:0] opa = '0, opb = '0;
  logic [2:0] fsel = '0;
  logic cin = 1'b0;
  logic [W-1:0] res;
  logic cout;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_alu #(.W(W)) i_nibble_alu (
    .opa(opa), .opb(opb), .fsel(fsel), .cin(cin), .res(res), .cout(cout)
  );

  task automatic model(input int a, input int b, input int f, input int ci,
                       output int er, output int ec);
    int y, sum, m;
    m = (1 << W) - 1;
    if (f < 4) begin
      case (f & 3)
        0: y = 0;
        1: y = b;
        2: y = ~b & m;
        default: y = m;
      endcase
      sum = a + y + ci;
      er = sum & m;
      ec = (sum >> W) & 1;
    end else begin
      case (f & 3)
        0: er = a | b;
        1: er = a ^ b;
        2: er = a & b;
        default: er = ~a & m;
      endcase
      ec = 0;
    end
  endtask

  task automatic compare(input string tag_r, input string tag_c,
                         input int er, input int ec);
    checks++;
    if (int'(res) != er) begin
      fails++;
      $display("FAIL %s res: fsel=%0d cin=%0d a=%0d b=%0d actual=%0d expected=%0d",
               tag_r, fsel, cin, opa, opb, res, er);
    end
    checks++;
    if (int'(cout) != ec) begin
      fails++;
      $display("FAIL %s cout: fsel=%0d cin=%0d a=%0d b=%0d actual=%0d expected=%0d",
               tag_c, fsel, cin, opa, opb, cout, ec);
    end
  endtask

  function automatic string res_tag(input int f);
    if (f >= 4) return "R5";
    if (f == 2) return "R3";
    if (f == 3) return "R4";
    return "R1";
  endfunction

  function automatic string cout_tag(input int f);
    if (f >= 4) return "R6";
    if (f == 2) return "R3";
    if (f == 3) return "R4";
    return "R2";
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int er, ec;
    @(negedge clk);
    // R1: all-zero inputs, transfer of zero
    model(0, 0, 0, 0, er, ec);
    compare("R1", "R2", er, ec);

    for (int f = 0; f < 8; f++)
      for (int ci = 0; ci < 2; ci++)
        for (int a = 0; a < (1 << W); a++)
          for (int b = 0; b < (1 << W); b++) begin
            @(posedge clk);
            opa  <= W'(a);
            opb  <= W'(b);
            fsel <= 3'(f);
            cin  <= 1'(ci);
            @(negedge clk);
            model(a, b, f, ci, er, ec);
            compare(res_tag(f), cout_tag(f), er, ec);
          end

    // R7: inputs change between edges, outputs settle with no clock edge
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      opa  = W'(3 * k + 5);
      opb  = W'(7 * k + 2);
      fsel = 3'(2 * k + 1);
      cin  = 1'(k);
      #1;
      model(3 * k + 5 & 15, 7 * k + 2 & 15, 2 * k + 1, k & 1, er, ec);
      compare("R7", "R7", er, ec);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule